// File: doc/BRIEF.md
# Selectable-Rate Waveform Sample Capture

This block takes a snapshot of one internal data stream at a regular interval and holds it in a 40-bit waveform register. Each new snapshot is marked by a one-clock strobe that can set an interrupt flag. The interval is a power-of-two division of the master clock, picked by a 2-bit rate code. A 2-bit source code chooses what is captured: the filtered power value, channel 1 alone, channel 2 alone, or both channels packed into one word.

The block is controlled by a small state machine with three states. ST_HOLD is the state while the sample-mode enable is low. ST_COUNT is the state while the interval counter runs. ST_SAMPLE is the one cycle in which the register shows a fresh sample. The transitions are as follows. From ST_HOLD the machine goes to ST_COUNT when the enable is high. From ST_COUNT or ST_SAMPLE it goes to ST_HOLD when the enable is low. From ST_COUNT or ST_SAMPLE it goes to ST_SAMPLE when the interval counter expires. In every other case it goes to ST_COUNT. A change of rate code clears the counter and stops that cycle's expiry, so the next full interval starts from zero.

Top module: `wcap_wave_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `wave_q` is 0 and `wave_new` is 0. The stored rate code resets to 00.
- R2: While enabled, with fixed codes, consecutive strobes are N cycles apart. N is 128 for rate code 00, 256 for 01, 512 for 10 and 1024 for 11.
- R3: Source code 00 captures the 24-bit power value, sign-extended to 40 bits.
- R4: Source code 01 captures channel 1 in bits 39:20 and channel 2 in bits 19:0.
- R5: Source code 10 captures channel 1, sign-extended to 40 bits. Source code 11 captures channel 2, sign-extended to 40 bits.
- R6: `wave_new` is high for exactly one cycle. That cycle is the first cycle in which `wave_q` shows the new sample. In cycles without the strobe, `wave_q` does not change.
- R7: While `smp_en` is low, no capture occurs and the counter is held at zero. If `smp_en` is first sampled high in cycle c, the first strobe appears in cycle c+N.
- R8: If a new rate code first appears in cycle c, no strobe occurs in cycle c+1, and the first strobe appears in cycle c+1+N for the new N. This also holds when the change lands in the cycle in which a capture was due.
- R9: The source code and data are taken in the capture cycle only. Changing them between captures leaves `wave_q` and the capture interval unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample-mode enable |
| src_sel | input | 2 | Source code: 00 power, 01 both channels, 10 channel 1, 11 channel 2 |
| rate_sel | input | 2 | Rate code: interval of 128 << code master clocks |
| ch1_smp | input | 20 | Channel 1 sample, two's complement |
| ch2_smp | input | 20 | Channel 2 sample, two's complement |
| pwr_lpf | input | 24 | Filtered power value, two's complement |
| wave_q | output | 40 | Waveform register |
| wave_new | output | 1 | New-sample strobe, one cycle |

## Verification
Two events can fall in the same cycle: the counter expiring, and either a rate-code change or the enable dropping. In that case the restart or the hold must win, and the capture must be dropped. The bench provokes this case directly. It counts cycles from a strobe and switches the rate code, or lowers the enable, in exactly the cycle in which the next capture is due. It then checks that no strobe follows, and that the next strobe arrives after a full new interval. Random segments also mix data, source and rate changes and enable toggles. Every cycle of these segments is compared against a cycle model built from the requirements.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SAMPLE = 2'd2
    } wcap_state_e;

    typedef enum logic [1:0] {
        SRC_PWR  = 2'b00,
        SRC_BOTH = 2'b01,
        SRC_CH1  = 2'b10,
        SRC_CH2  = 2'b11
    } wcap_src_e;

endpackage

// File: rtl/wcap_rate_div.sv
module wcap_rate_div #(
    parameter int BASE_LOG2 = 7,
    parameter int RATE_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // terminal count = (2^(BASE_LOG2+rate)) - 1 : a run of ones
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < (BASE_LOG2 + int'(rate)));
        end
    end

    assign tick = !clr && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wcap_src_mux.sv
module wcap_src_mux
    import wcap_pkg::*;
#(
    parameter int CH_W  = 20,
    parameter int PWR_W = 24
) (
    input  logic [1:0]        src,
    input  logic [CH_W-1:0]   ch1,
    input  logic [CH_W-1:0]   ch2,
    input  logic [PWR_W-1:0]  pwr,
    output logic [2*CH_W-1:0] sample
);
    localparam int WAVE_W = 2 * CH_W;

    logic [WAVE_W-1:0] pwr_wide;
    logic [WAVE_W-1:0] ch1_wide;
    logic [WAVE_W-1:0] ch2_wide;

    generate
        if (PWR_W >= WAVE_W) begin : g_pwr_trunc
            assign pwr_wide = pwr[WAVE_W-1:0];
        end else begin : g_pwr_sext
            assign pwr_wide = {{(WAVE_W-PWR_W){pwr[PWR_W-1]}}, pwr};
        end
    endgenerate

    assign ch1_wide = {{CH_W{ch1[CH_W-1]}}, ch1};
    assign ch2_wide = {{CH_W{ch2[CH_W-1]}}, ch2};

    always_comb begin
        unique case (wcap_src_e'(src))
            SRC_PWR:  sample = pwr_wide;
            SRC_BOTH: sample = {ch1, ch2};
            SRC_CH1:  sample = ch1_wide;
            SRC_CH2:  sample = ch2_wide;
            default:  sample = '0;
        endcase
    end

endmodule

// File: rtl/wcap_wave_capture.sv
module wcap_wave_capture
    import wcap_pkg::*;
#(
    parameter int CH_W      = 20,
    parameter int PWR_W     = 24,
    parameter int BASE_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_en,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        rate_sel,
    input  logic [CH_W-1:0]   ch1_smp,
    input  logic [CH_W-1:0]   ch2_smp,
    input  logic [PWR_W-1:0]  pwr_lpf,
    output logic [2*CH_W-1:0] wave_q,
    output logic              wave_new
);
    localparam int WAVE_W = 2 * CH_W;
    localparam int RATE_W = 2;

    wcap_state_e       state_q, state_d;
    logic [RATE_W-1:0] rate_q;
    logic              rate_chg;
    logic              div_clr;
    logic              div_tick;
    logic [WAVE_W-1:0] sample;

    // a rate code differing from the one last seen restarts the interval
    assign rate_chg = (rate_sel != rate_q);
    assign div_clr  = !smp_en || rate_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else begin
            rate_q <= rate_sel;
        end
    end

    wcap_rate_div #(
        .BASE_LOG2 (BASE_LOG2),
        .RATE_W    (RATE_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (div_clr),
        .rate (rate_q),
        .tick (div_tick)
    );

    wcap_src_mux #(
        .CH_W  (CH_W),
        .PWR_W (PWR_W)
    ) u_mux (
        .src    (src_sel),
        .ch1    (ch1_smp),
        .ch2    (ch2_smp),
        .pwr    (pwr_lpf),
        .sample (sample)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (smp_en) state_d = ST_COUNT;
            end
            ST_COUNT, ST_SAMPLE: begin
                if (!smp_en)       state_d = ST_HOLD;
                else if (div_tick) state_d = ST_SAMPLE;
                else               state_d = ST_COUNT;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs
    assign wave_new = (state_q == ST_SAMPLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= '0;
        end else if (state_d == ST_SAMPLE) begin
            wave_q <= sample;
        end
    end

endmodule

// File: rtl/wcap_wave_capture_chk.sv
module wcap_wave_capture_chk #(
    parameter int CH_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_en,
    input logic [1:0]        src_sel,
    input logic [1:0]        rate_sel,
    input logic [CH_W-1:0]   ch1_smp,
    input logic [CH_W-1:0]   ch2_smp,
    input logic [2*CH_W-1:0] wave_q,
    input logic              wave_new
);

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        wave_new |=> !wave_new);

    p_reg_steady_r6: assert property (@(posedge clk) disable iff (rst)
        !wave_new |-> $stable(wave_q));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !wave_new);

    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> !wave_new);

    p_pack_r4: assert property (@(posedge clk) disable iff (rst)
        (wave_new && $past(src_sel) == 2'b01)
            |-> wave_q == {$past(ch1_smp), $past(ch2_smp)});

    p_ch1_sext_r5: assert property (@(posedge clk) disable iff (rst)
        (wave_new && $past(src_sel) == 2'b10)
            |-> wave_q == {{CH_W{$past(ch1_smp[CH_W-1])}}, $past(ch1_smp)});

endmodule

bind wcap_wave_capture wcap_wave_capture_chk #(.CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .src_sel  (src_sel),
    .rate_sel (rate_sel),
    .ch1_smp  (ch1_smp),
    .ch2_smp  (ch2_smp),
    .wave_q   (wave_q),
    .wave_new (wave_new)
);

// File: tb/wcap_wave_capture_tb.sv
`timescale 1ns/1ps
module wcap_wave_capture_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_en;
    logic [1:0]  src_sel, rate_sel;
    logic [19:0] ch1_smp, ch2_smp;
    logic [23:0] pwr_lpf;
    logic [39:0] wave_q;
    logic        wave_new;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit cmp_on = 0;
    string ph  = "R1";

    logic [1:0]  m_rate;
    int          m_cnt;
    logic [39:0] m_q;
    logic        m_new;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wcap_wave_capture u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .src_sel(src_sel),
        .rate_sel(rate_sel), .ch1_smp(ch1_smp), .ch2_smp(ch2_smp),
        .pwr_lpf(pwr_lpf), .wave_q(wave_q), .wave_new(wave_new)
    );

    function automatic logic [39:0] exp_sample(input logic [1:0] s,
        input logic [19:0] c1, input logic [19:0] c2, input logic [23:0] p);
        case (s)
            2'b00:   return {{16{p[23]}}, p};
            2'b01:   return {c1, c2};
            2'b10:   return {{20{c1[19]}}, c1};
            default: return {{20{c2[19]}}, c2};
        endcase
    endfunction

    task automatic check(input string tag, input bit ok,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_rate <= 2'b00; m_cnt <= 0; m_q <= '0; m_new <= 1'b0;
        end else begin
            m_rate <= rate_sel;
            if (!smp_en || rate_sel != m_rate) begin
                m_cnt <= 0; m_new <= 1'b0;
            end else if (m_cnt == (128 << m_rate) - 1) begin
                m_cnt <= 0; m_new <= 1'b1;
                m_q <= exp_sample(src_sel, ch1_smp, ch2_smp, pwr_lpf);
            end else begin
                m_cnt <= m_cnt + 1; m_new <= 1'b0;
            end
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (cmp_on) begin
            check({ph, " strobe"}, wave_new === m_new, 64'(wave_new), 64'(m_new));
            check({ph, " data"}, wave_q === m_q, 64'(wave_q), 64'(m_q));
        end
    end

    task automatic tick_wait();
        @(negedge clk); #2;
    endtask

    task automatic wait_strobe(output int at);
        do tick_wait(); while (!wave_new);
        at = cyc;
    endtask

    task automatic wait_cycle(input int target);
        while (cyc < target) tick_wait();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, k, n;
        logic [39:0] held;
        void'($urandom(32'h5EED_0042));
        rst = 1; smp_en = 0; src_sel = 0; rate_sel = 0;
        ch1_smp = 0; ch2_smp = 0; pwr_lpf = 0;
        repeat (5) tick_wait();
        check("R1 reset", wave_q == 0 && !wave_new, {23'd0, wave_new, wave_q}, 64'd0);
        rst = 0;
        tick_wait();
        check("R1 release", wave_q == 0 && !wave_new, {23'd0, wave_new, wave_q}, 64'd0);
        cmp_on = 1;

        // R2: interval per rate code
        ph = "R2";
        ch1_smp = 20'h12345; ch2_smp = 20'hABCDE; pwr_lpf = 24'h876543;
        smp_en = 1;
        for (int c = 0; c < 4; c++) begin
            rate_sel = 2'(c);
            wait_strobe(t0); wait_strobe(t1);
            check("R2 interval", (t1 - t0) == (128 << c), 64'(t1 - t0), 64'(128 << c));
        end

        // R3 R4 R5: source codes
        rate_sel = 0;
        for (int s = 0; s < 4; s++) begin
            ph = (s == 0) ? "R3" : (s == 1) ? "R4" : "R5";
            src_sel = 2'(s);
            ch1_smp = (s % 2 == 0) ? 20'h80F01 : 20'h7A0B1;
            ch2_smp = (s == 3) ? 20'hF0002 : 20'h0C0C3;
            pwr_lpf = 24'hC00011;
            wait_strobe(t0);
            check(ph, wave_q == exp_sample(2'(s), ch1_smp, ch2_smp, pwr_lpf),
                  64'(wave_q), 64'(exp_sample(2'(s), ch1_smp, ch2_smp, pwr_lpf)));
        end

        // R9: changes between captures have no effect
        ph = "R9";
        wait_strobe(t0);
        held = wave_q;
        src_sel = 2'b01; ch1_smp = 20'h11111; ch2_smp = 20'h22222;
        repeat (50) tick_wait();
        check("R9 held", wave_q == held, 64'(wave_q), 64'(held));
        wait_strobe(t1);
        check("R9 interval", (t1 - t0) == 128, 64'(t1 - t0), 64'd128);
        check("R9 data", wave_q == 40'h1111122222, 64'(wave_q), 64'h1111122222);

        // R7: hold while disabled
        ph = "R7";
        smp_en = 0; n = 0; held = wave_q;
        repeat (2000) begin tick_wait(); if (wave_new) n++; end
        check("R7 no strobe", n == 0, 64'(n), 64'd0);
        check("R7 held", wave_q == held, 64'(wave_q), 64'(held));
        smp_en = 1; k = cyc;
        wait_strobe(t1);
        check("R7 first", (t1 - k) == 128, 64'(t1 - k), 64'd128);

        // R7 coincidence: enable drops in the due cycle
        wait_strobe(t0);
        wait_cycle(t0 + 127);
        smp_en = 0;
        tick_wait();
        check("R7 drop at due", !wave_new, 64'(wave_new), 64'd0);
        smp_en = 1; k = cyc;
        wait_strobe(t1);
        check("R7 resume", (t1 - k) == 128, 64'(t1 - k), 64'd128);

        // R8: rate change restart
        ph = "R8";
        wait_strobe(t0);
        repeat (60) tick_wait();
        rate_sel = 2'b01; k = cyc;
        wait_strobe(t1);
        check("R8 restart", (t1 - k) == 257, 64'(t1 - k), 64'd257);
        wait_strobe(t0);
        wait_cycle(t0 + 255);
        rate_sel = 2'b00; k = cyc;
        tick_wait();
        check("R8 due dropped", !wave_new, 64'(wave_new), 64'd0);
        wait_strobe(t1);
        check("R8 coincide", (t1 - k) == 129, 64'(t1 - k), 64'd129);

        // R6: random segments against the cycle model
        ph = "R6";
        for (int seg = 0; seg < 40; seg++) begin
            rate_sel = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
            src_sel  = 2'($urandom % 4);
            smp_en   = (($urandom % 6) != 0);
            for (int i = 0; i < 700; i++) begin
                tick_wait();
                ch1_smp = 20'($urandom); ch2_smp = 20'($urandom);
                pwr_lpf = 24'($urandom);
                if (($urandom % 97) == 0) src_sel = 2'($urandom % 4);
                if (($urandom % 401) == 0) smp_en = ~smp_en;
            end
        end

        cmp_on = 0;
        tick_wait();
        finish_run();
    end

endmodule